// File: doc/BRIEF.md
# UART Register Front End with Prioritized Interrupt Identification

This block is the host-facing register file of a 16550-style serial controller. It decodes a small register window, including the divisor-latch bytes that replace the data and interrupt-enable registers while the latch-access bit of the line-control register is set. It holds the interrupt-enable, line-control, modem-control and scratch registers and the FIFO-mode flag. It also keeps a sticky overrun flag and a transmit-empty event.

Receive occupancy, the head receive byte, overrun events and the modem status byte come from neighbouring blocks. Data writes go out as a one-cycle load strobe with the byte. Data reads and modem-status reads pulse pop and acknowledge strobes back to those neighbours.

From its state the block computes one identification value by fixed priority and drives a single level interrupt. Every access takes one cycle. Read data is registered and is valid on the cycle after the access. The interrupt output is registered from the state after each cycle, so it always reflects the most recent access.

Top module: `uart_irq_regfront`

## Requirements
- R1: After reset the interrupt is low, the pulse outputs are low, the enable, line-control, modem-control and scratch registers are 0, FIFO mode is off, and the divisor bytes are low=12 and high=0 (reference 1843200 Hz / 9600 baud / 16).
- R2: While line-control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. While the bit is 0, these offsets reach data and interrupt enable.
- R3: The interrupt-enable register (offset 1) keeps only bits 3:0, so a read returns bits 7:4 as 0. The bit roles are: bit0 receive, bit1 transmit-empty, bit2 line status, bit3 modem.
- R4: A read of offset 2 returns the highest-priority enabled reason, in this order: overrun (0x06), receive level non-zero (0x0C), transmit-empty pending (0x02), modem delta in modem-status bits 3:0 (0x00). With no enabled reason it returns 0x01.
- R5: Each data write (offset 0, latch-access bit 0) sets the transmit-empty pending flag. An identification read clears the flag only when it returns 0x02.
- R6: A write to offset 2 sets FIFO mode from data bit 0. While FIFO mode is on, identification reads have bits 7:6 set.
- R7: A line-status read (offset 5) returns bit6=1, bit5=1, bit1=overrun, bit0=(receive level non-zero), and all other bits 0. The overrun bit is set by an overrun event and cleared by the read, unless a new event arrives in the same cycle.
- R8: The interrupt output is high exactly one cycle after a cycle whose state has an enabled pending reason, and low otherwise.
- R9: Reads of offsets 8 and above return 0xFF. Writes to the line-status and modem-status offsets (5, 6) change nothing.
- R10: A data read returns the receive head byte and pulses the pop output when the receive level is non-zero. Otherwise it returns 0xFF without a pop.
- R11: Modem control (offset 4) keeps bits 4:0. Line control (offset 3) and scratch (offset 7) read back the full byte.
- R12: A data write pulses the load output with the byte for one cycle. A modem-status read returns the modem input byte and pulses the acknowledge output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register offset |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after a read |
| rd_valid | output | 1 | Read data valid strobe |
| tx_byte | output | 8 | Byte for the transmit engine |
| tx_load | output | 1 | One-cycle strobe for tx_byte |
| rx_head | input | 8 | Oldest received byte |
| rx_level | input | CNT_W | Receive occupancy |
| rx_pop | output | 1 | Pop strobe to the receive buffer |
| ovr_event | input | 1 | Overrun event pulse |
| modem_stat | input | 8 | Modem status byte, delta bits 3:0 |
| modem_rd | output | 1 | Modem status read acknowledge |
| irq | output | 1 | Level interrupt request |

## Verification
A stale or wrong transmit-empty flag shows up at the ports as an identification value that skips to the next reason or repeats 0x02. It also shows up as an interrupt that stays high or never rises. Both are visible on the first identification read, and the interrupt shows it one cycle after the access. A sticky overrun that fails to clear shows up on the second line-status read as bit 1 still set, and it holds the identification at 0x06 with FIFO bits. The bench therefore reads the identification value repeatedly while it removes reasons one at a time. This makes every step of the priority chain and every clearing rule visible at the port.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [7:0] IID_NONE = 8'h01;
  localparam logic [7:0] IID_LS   = 8'h06;
  localparam logic [7:0] IID_TMO  = 8'h0C;
  localparam logic [7:0] IID_TX   = 8'h02;
  localparam logic [7:0] IID_MS   = 8'h00;

  typedef enum logic [2:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } ofs_e;

  // interrupt sources, highest priority first
  typedef struct packed {
    logic ovr;
    logic rx;
    logic tx;
    logic ms;
  } src_t;

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  src_t       req,
  input  logic [3:0] en,
  output logic [7:0] code,
  output logic       pending
);

  src_t live;

  // enable roles: bit0 rx, bit1 tx, bit2 line status, bit3 modem
  assign live.ovr = req.ovr & en[2];
  assign live.rx  = req.rx  & en[0];
  assign live.tx  = req.tx  & en[1];
  assign live.ms  = req.ms  & en[3];

  always_comb begin
    if (live.ovr)      code = IID_LS;
    else if (live.rx)  code = IID_TMO;
    else if (live.tx)  code = IID_TX;
    else if (live.ms)  code = IID_MS;
    else               code = IID_NONE;
  end

  assign pending = |live;

endmodule

// File: rtl/uart_irq_lsr.sv
module uart_irq_lsr (
  input  logic       clk,
  input  logic       rst,
  input  logic       ovr_event,
  input  logic       rd_stb,
  input  logic       rx_any,
  output logic       oe,
  output logic [7:0] lsr_val
);

  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst)            oe_q <= 1'b0;
    else if (ovr_event) oe_q <= 1'b1;
    else if (rd_stb)    oe_q <= 1'b0;
  end

  assign oe      = oe_q;
  // bit6 shifter empty, bit5 holding empty: the transmitter is always ready
  assign lsr_val = {1'b0, 1'b1, 1'b1, 3'b000, oe_q, rx_any};

  p_oe_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !ovr_event) |=> !oe_q);

  p_oe_set_r7: assert property (@(posedge clk) disable iff (rst)
    ovr_event |=> oe_q);

endmodule

// File: rtl/uart_irq_divlatch.sv
module uart_irq_divlatch #(
  parameter int DIV_W     = 16,
  parameter int RESET_DIV = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] lo,
  output logic [7:0] hi
);

  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RESET_DIV);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= RST_VAL;
    end else begin
      if (wr_lo) div_q[7:0]  <= wdata;
      if (wr_hi) div_q[15:8] <= wdata;
    end
  end

  assign lo = div_q[7:0];
  assign hi = div_q[15:8];

endmodule

// File: rtl/uart_irq_regfront.sv
module uart_irq_regfront
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int REF_HZ     = 1843200,
  parameter int BAUD       = 9600,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_load,
  input  logic [7:0]        rx_head,
  input  logic [CNT_W-1:0]  rx_level,
  output logic              rx_pop,
  input  logic              ovr_event,
  input  logic [7:0]        modem_stat,
  output logic              modem_rd,
  output logic              irq
);

  localparam int RESET_DIV = REF_HZ / BAUD / 16;

  // ---------------- decode ----------------
  logic in_map;
  generate
    if (ADDR_W > 3) begin : g_wide
      assign in_map = (acc_addr[ADDR_W-1:3] == '0);
    end else begin : g_narrow
      assign in_map = 1'b1;
    end
  endgenerate

  ofs_e ofs;
  assign ofs = ofs_e'(acc_addr[2:0]);

  logic [7:0] lcr_q;
  logic       dlab;
  assign dlab = lcr_q[7];

  logic hit, hit_wr, hit_rd;
  assign hit    = acc_en & in_map;
  assign hit_wr = hit & acc_we;
  assign hit_rd = hit & ~acc_we;

  logic wr_dl_lo, wr_dl_hi, wr_data, wr_ien, wr_fcr, wr_lcr, wr_mcr, wr_scr;
  logic rd_data_s, rd_iid, rd_lsr, rd_msr;

  assign wr_dl_lo  = hit_wr &  dlab & (ofs == OFS_DATA);
  assign wr_dl_hi  = hit_wr &  dlab & (ofs == OFS_IEN);
  assign wr_data   = hit_wr & ~dlab & (ofs == OFS_DATA);
  assign wr_ien    = hit_wr & ~dlab & (ofs == OFS_IEN);
  assign wr_fcr    = hit_wr & (ofs == OFS_IID);
  assign wr_lcr    = hit_wr & (ofs == OFS_LCTL);
  assign wr_mcr    = hit_wr & (ofs == OFS_MCTL);
  assign wr_scr    = hit_wr & (ofs == OFS_SCR);
  assign rd_data_s = hit_rd & ~dlab & (ofs == OFS_DATA);
  assign rd_iid    = hit_rd & (ofs == OFS_IID);
  assign rd_lsr    = hit_rd & (ofs == OFS_LSTAT);
  assign rd_msr    = hit_rd & (ofs == OFS_MSTAT);

  // ---------------- state ----------------
  logic [3:0] ier_q;
  logic [4:0] mcr_q;
  logic [7:0] scr_q;
  logic       fifo_en_q;
  logic       thre_q;

  logic       rx_any;
  assign rx_any = (rx_level != '0);

  logic [7:0] dl_lo, dl_hi;
  uart_irq_divlatch #(
    .DIV_W     (16),
    .RESET_DIV (RESET_DIV)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .wr_lo (wr_dl_lo),
    .wr_hi (wr_dl_hi),
    .wdata (acc_wdata),
    .lo    (dl_lo),
    .hi    (dl_hi)
  );

  logic       oe;
  logic [7:0] lsr_val;
  uart_irq_lsr u_lsr (
    .clk       (clk),
    .rst       (rst),
    .ovr_event (ovr_event),
    .rd_stb    (rd_lsr),
    .rx_any    (rx_any),
    .oe        (oe),
    .lsr_val   (lsr_val)
  );

  src_t       req;
  logic [7:0] code;
  logic       pend;
  assign req.ovr = oe;
  assign req.rx  = rx_any;
  assign req.tx  = thre_q;
  assign req.ms  = |modem_stat[3:0];

  uart_irq_prio u_prio (
    .req     (req),
    .en      (ier_q),
    .code    (code),
    .pending (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q     <= '0;
      lcr_q     <= '0;
      mcr_q     <= '0;
      scr_q     <= '0;
      fifo_en_q <= 1'b0;
    end else begin
      if (wr_ien) ier_q     <= acc_wdata[3:0];
      if (wr_lcr) lcr_q     <= acc_wdata;
      if (wr_mcr) mcr_q     <= acc_wdata[4:0];
      if (wr_scr) scr_q     <= acc_wdata;
      if (wr_fcr) fifo_en_q <= acc_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            thre_q <= 1'b0;
    else if (wr_data)                   thre_q <= 1'b1;
    else if (rd_iid && code == IID_TX)  thre_q <= 1'b0;
  end

  // ---------------- read mux ----------------
  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = 8'hFF;
    if (in_map) begin
      case (ofs)
        OFS_DATA:  rd_mux = dlab ? dl_lo : (rx_any ? rx_head : 8'hFF);
        OFS_IEN:   rd_mux = dlab ? dl_hi : {4'b0000, ier_q};
        OFS_IID:   rd_mux = {fifo_en_q, fifo_en_q, 6'b000000} | code;
        OFS_LCTL:  rd_mux = lcr_q;
        OFS_MCTL:  rd_mux = {3'b000, mcr_q};
        OFS_LSTAT: rd_mux = lsr_val;
        OFS_MSTAT: rd_mux = modem_stat;
        OFS_SCR:   rd_mux = scr_q;
        default:   rd_mux = 8'hFF;
      endcase
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      tx_byte  <= '0;
      tx_load  <= 1'b0;
      rx_pop   <= 1'b0;
      modem_rd <= 1'b0;
      irq      <= 1'b0;
    end else begin
      rd_valid <= hit_rd | (acc_en & ~acc_we & ~in_map);
      if (acc_en && !acc_we) rd_data <= rd_mux;
      tx_load  <= wr_data;
      if (wr_data) tx_byte <= acc_wdata;
      rx_pop   <= rd_data_s & rx_any;
      modem_rd <= rd_msr;
      irq      <= pend;
    end
  end

  // ---------------- assertions ----------------
  p_thre_set_r5: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> thre_q);

  p_tx_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_iid && code == IID_TX) |=> !thre_q);

  p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(rx_level != '0));

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (ier_q == 4'h0) |=> !irq);

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_pop, modem_rd, tx_load}));

  p_div_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !dlab |=> $stable(dl_lo));

endmodule

// File: tb/uart_irq_regfront_tb.sv
module uart_irq_regfront_tb;

  localparam int ADDR_W = 4;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic              acc_en, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [7:0]        acc_wdata;
  logic [7:0]        rd_data;
  logic              rd_valid;
  logic [7:0]        tx_byte;
  logic              tx_load;
  logic [7:0]        rx_head;
  logic [CNT_W-1:0]  rx_level;
  logic              rx_pop;
  logic              ovr_event;
  logic [7:0]        modem_stat;
  logic              modem_rd;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_irq_regfront #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .tx_byte(tx_byte), .tx_load(tx_load),
    .rx_head(rx_head), .rx_level(rx_level), .rx_pop(rx_pop),
    .ovr_event(ovr_event), .modem_stat(modem_stat), .modem_rd(modem_rd),
    .irq(irq)
  );

  typedef struct packed {
    logic       we;
    logic [3:0] addr;
    logic [7:0] wd;
    logic       chk;
    logic [7:0] exp;
    logic       eirq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 4'd3, 8'h00, 1'b1, 8'h00, 1'b0}, // R1 line control 0
    '{1'b0, 4'd1, 8'h00, 1'b1, 8'h00, 1'b0}, // R1 enable 0
    '{1'b0, 4'd7, 8'h00, 1'b1, 8'h00, 1'b0}, // R1 scratch 0
    '{1'b1, 4'd3, 8'h80, 1'b0, 8'h00, 1'b0}, // R2 latch access on
    '{1'b0, 4'd0, 8'h00, 1'b1, 8'h0C, 1'b0}, // R1 R2 divisor low 12
    '{1'b0, 4'd1, 8'h00, 1'b1, 8'h00, 1'b0}, // R1 R2 divisor high 0
    '{1'b1, 4'd0, 8'h34, 1'b0, 8'h00, 1'b0}, // R2 write low
    '{1'b1, 4'd1, 8'h12, 1'b0, 8'h00, 1'b0}, // R2 write high
    '{1'b0, 4'd0, 8'h00, 1'b1, 8'h34, 1'b0}, // R2
    '{1'b0, 4'd1, 8'h00, 1'b1, 8'h12, 1'b0}, // R2
    '{1'b1, 4'd3, 8'h03, 1'b0, 8'h00, 1'b0}, // R11 latch off
    '{1'b0, 4'd3, 8'h00, 1'b1, 8'h03, 1'b0}, // R11
    '{1'b1, 4'd1, 8'hFF, 1'b0, 8'h00, 1'b0}, // R3 all enables
    '{1'b0, 4'd1, 8'h00, 1'b1, 8'h0F, 1'b0}, // R3 masked
    '{1'b1, 4'd0, 8'h41, 1'b0, 8'h00, 1'b1}, // R5 data write -> pending
    '{1'b0, 4'd2, 8'h00, 1'b1, 8'h02, 1'b0}, // R5 reported and cleared
    '{1'b0, 4'd2, 8'h00, 1'b1, 8'h01, 1'b0}, // R4 nothing pending
    '{1'b1, 4'd2, 8'h01, 1'b0, 8'h00, 1'b0}, // R6 fifo on
    '{1'b1, 4'd7, 8'h5A, 1'b0, 8'h00, 1'b0}, // R11
    '{1'b0, 4'd7, 8'h00, 1'b1, 8'h5A, 1'b0}, // R11
    '{1'b1, 4'd4, 8'hFF, 1'b0, 8'h00, 1'b0}, // R11 modem control
    '{1'b0, 4'd4, 8'h00, 1'b1, 8'h1F, 1'b0}  // R11 masked
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    acc(1'b0, a, 8'h00);
    chk(tag, rd_data, exp);
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic ovr_pulse();
    @(negedge clk); ovr_event = 1'b1;
    @(negedge clk); ovr_event = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; acc_en = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
    rx_head = 8'h00; rx_level = '0; ovr_event = 1'b0; modem_stat = 8'h00;
    settle(4);
    rst = 1'b0;
    settle(1);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    chk("R1 strobes after reset", {4'b0, rd_valid, tx_load, rx_pop, modem_rd}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].we, VEC[i].addr, VEC[i].wd);
      if (VEC[i].chk) chk($sformatf("table %0d read", i), rd_data, VEC[i].exp);
      settle(1);
      chk($sformatf("R8 table %0d irq", i), {7'b0, irq}, {7'b0, VEC[i].eirq});
    end

    // R9 out-of-map read, status writes ignored
    rd(4'd9, 8'hFF, "R9 undefined offset");
    acc(1'b1, 4'd5, 8'h00);
    rd(4'd5, 8'h60, "R9 R7 line status after write");
    modem_stat = 8'h30;
    acc(1'b1, 4'd6, 8'h55);
    rd(4'd6, 8'h30, "R9 modem status after write");
    chk("R12 modem ack", {7'b0, modem_rd}, 8'h01);

    // R12 transmit strobe
    acc(1'b1, 4'd0, 8'h99);
    chk("R12 load strobe", {7'b0, tx_load}, 8'h01);
    chk("R12 load byte", tx_byte, 8'h99);
    settle(1);
    chk("R8 irq on tx pending", {7'b0, irq}, 8'h01);

    // R4 R5 receive outranks tx, tx not cleared
    rx_level = 5'd3; rx_head = 8'h77;
    settle(2);
    rd(4'd2, 8'hCC, "R4 R6 receive code");
    rd(4'd0, 8'h77, "R10 head byte");
    chk("R10 pop strobe", {7'b0, rx_pop}, 8'h01);
    rx_level = '0;
    settle(1);
    rd(4'd2, 8'hC2, "R5 tx still pending");
    rd(4'd2, 8'hC1, "R5 tx cleared");
    rd(4'd0, 8'hFF, "R10 empty read");
    chk("R10 no pop when empty", {7'b0, rx_pop}, 8'h00);

    // R4 full chain
    modem_stat = 8'h01; rx_level = 5'd2;
    acc(1'b1, 4'd0, 8'h10);
    ovr_pulse();
    settle(1);
    chk("R8 irq all pending", {7'b0, irq}, 8'h01);
    rd(4'd2, 8'hC6, "R4 overrun first");
    rd(4'd5, 8'h63, "R7 status with overrun");
    rd(4'd5, 8'h61, "R7 overrun cleared");
    rd(4'd2, 8'hCC, "R4 receive second");
    rx_level = '0;
    settle(1);
    rd(4'd2, 8'hC2, "R4 tx third");
    rd(4'd2, 8'hC0, "R4 modem fourth");
    modem_stat = 8'h00;
    settle(1);
    rd(4'd2, 8'hC1, "R4 none");
    settle(1);
    chk("R8 irq low", {7'b0, irq}, 8'h00);

    // R8 masked sources
    acc(1'b1, 4'd1, 8'h00);
    acc(1'b1, 4'd0, 8'h20);
    ovr_pulse();
    rx_level = 5'd1;
    settle(2);
    chk("R8 masked irq", {7'b0, irq}, 8'h00);
    rd(4'd2, 8'hC1, "R4 masked none");
    acc(1'b1, 4'd1, 8'h02);
    settle(1);
    chk("R8 tx enable irq", {7'b0, irq}, 8'h01);
    rd(4'd2, 8'hC2, "R5 tx after unmask");
    rd(4'd5, 8'h63, "R7 masked overrun kept");
    rx_level = '0;

    // R6 fifo off
    acc(1'b1, 4'd2, 8'h00);
    rd(4'd2, 8'h01, "R6 fifo bits off");

    done = 1'b1;
    finish_run();
  end

endmodule